// File: doc/BRIEF.md
# Indirect Pattern Memory Access Port

This block lets a host reach a 64-entry, 40-bit pattern memory through three 16-bit registers: a control register, a low data register and a high data register. A mode bit in the control register switches between matching mode and programming mode. In matching mode the block raises an enable output for a pattern matcher, which lives outside this block. The host is then locked out of the memory. In programming mode the host loads a word address. It can then read that word through the three registers in any order, or rewrite it with an ordered sequence of register writes.

A new word is only committed when the write sequence finishes, so a half-done update never becomes visible to the matcher. The memory has no reset, so its contents survive block reset. The matcher reads the memory through a separate asynchronous read port.

Top module: `pattern_mem_port`

## Requirements
- R1: On reset, `matchEnable` is 0, the address field is 0 and the write sequence is idle. `regRdData` is 0 in any cycle where `regRdEn` is low.
- R2: A write to the control register (`regSel`=0) sets `matchEnable` from bit 7 of the written data, starting in the next cycle.
- R3: While `matchEnable` is 1, writes to the data registers (`regSel`=1, 2) and to bits 15:8 and 6:0 of the control register are ignored. The memory and the stored address stay unchanged.
- R4: While `matchEnable` is 1, a control register read returns 16'h0080 and a data register read returns 0.
- R5: A control register write with bit 7 at 0 loads bits 6:0 as the address. Bits 5:0 select the word, and bit 6 is kept and read back.
- R6: In programming mode, reads work in any order. The control register returns {word bits 7:0, 1'b0, address}, the low register returns word bits 23:8 and the high register returns word bits 39:24. Reads do not disturb a write sequence.
- R7: The write sequence is a control write (bit 7 = 0), then a low write, then a high write. At the high write, the word becomes {high data, low data, control bits 15:8}. It does not change before that point.
- R8: A write that breaks the order is ignored as a data step, and the sequence restarts. This covers a high write that does not directly follow an in-order low write, a repeated low write, and any write with `regSel`=3. A control write always restarts the sequence at its first step.
- R9: `mrdData` always shows the memory word at `mrdAddr`.
- R10: Memory contents are kept through reset. A sequence that reset interrupts commits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regSel | input | 2 | 0 control, 1 data low, 2 data high, 3 unused |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data (combinational) |
| matchEnable | output | 1 | Matching mode active |
| mrdAddr | input | 6 | Matcher read address |
| mrdData | output | 40 | Matcher read data |

## Verification
The assertions assume that `regWrEn` and `regRdEn` are never both high in one cycle. They also assume that every input is known whenever reset is deasserted. The bench issues one register access per cycle with each strobe held for exactly one cycle, and it drives all inputs to defined values from time zero. Words are always written before their contents are compared. Where a word has never been written, the byte lanes read from it are masked out of the comparison.

// File: rtl/pattern_mem_pkg.sv
package pattern_mem_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_LO   = 2'd1,
    SEL_HI   = 2'd2,
    SEL_NONE = 2'd3
  } regSel_e;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ADDR = 2'd1,
    SEQ_LO   = 2'd2
  } seq_e;

  typedef struct packed {
    logic takeAddr;
    logic takeLo;
    logic commit;
  } strobe_t;
endpackage

// File: rtl/pattern_mem_ctrl.sv
module pattern_mem_ctrl
  import pattern_mem_pkg::*;
#(
  parameter int REG_W   = 16,
  parameter int FIELD_W = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [1:0]         regSel,
  input  logic [REG_W-1:0]   regWrData,
  output logic               matchEnable,
  output logic [FIELD_W-1:0] wordAddr,
  output strobe_t            strb
);
  seq_e    seqState, seqNext;
  regSel_e selDec;
  logic    ctlWr, newMode;

  assign selDec  = regSel_e'(regSel);
  assign ctlWr   = regWrEn && (selDec == SEL_CTRL);
  assign newMode = regWrData[FIELD_W];

  always_comb begin
    strb    = '0;
    seqNext = seqState;
    if (regWrEn) begin
      unique case (selDec)
        SEL_CTRL: begin
          strb.takeAddr = !newMode;
          seqNext       = newMode ? SEQ_IDLE : SEQ_ADDR;
        end
        SEL_LO: begin
          strb.takeLo = !matchEnable && (seqState == SEQ_ADDR);
          seqNext     = strb.takeLo ? SEQ_LO : SEQ_IDLE;
        end
        SEL_HI: begin
          strb.commit = !matchEnable && (seqState == SEQ_LO);
          seqNext     = SEQ_IDLE;
        end
        default: seqNext = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      matchEnable <= 1'b0;
      wordAddr    <= '0;
      seqState    <= SEQ_IDLE;
    end else begin
      seqState <= seqNext;
      if (ctlWr) matchEnable <= newMode;
      if (strb.takeAddr) wordAddr <= regWrData[FIELD_W-1:0];
    end
  end

  AST_MODE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    ctlWr |=> matchEnable == $past(regWrData[FIELD_W])); // R2
  AST_LOCK_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    ($past(matchEnable) && matchEnable) |-> $stable(wordAddr)); // R3
  AST_LOCK_SEQ_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    matchEnable |-> seqState == SEQ_IDLE); // R3
endmodule

// File: rtl/pattern_mem_dp.sv
module pattern_mem_dp
  import pattern_mem_pkg::*;
#(
  parameter int REG_W   = 16,
  parameter int WORD_W  = 40,
  parameter int DEPTH   = 64,
  parameter int FIELD_W = 7
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobe_t                    strb,
  input  logic                       matchEnable,
  input  logic [FIELD_W-1:0]         wordAddr,
  input  logic                       regRdEn,
  input  logic [1:0]                 regSel,
  input  logic [REG_W-1:0]           regWrData,
  output logic [REG_W-1:0]           regRdData,
  input  logic [$clog2(DEPTH)-1:0]   mrdAddr,
  output logic [WORD_W-1:0]          mrdData
);
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int BYTE_W = WORD_W - 2 * REG_W;

  logic [WORD_W-1:0] memArr [DEPTH];
  logic [BYTE_W-1:0] stageByte0;
  logic [REG_W-1:0]  stageLo;
  logic [IDX_W-1:0]  wordIdx;
  logic [WORD_W-1:0] curWord;
  regSel_e           selDec;

  assign wordIdx = wordAddr[IDX_W-1:0];
  assign curWord = memArr[wordIdx];
  assign mrdData = memArr[mrdAddr];
  assign selDec  = regSel_e'(regSel);

  always_ff @(posedge clk) begin
    if (strb.takeAddr) stageByte0 <= regWrData[REG_W-1:REG_W-BYTE_W];
    if (strb.takeLo)   stageLo    <= regWrData;
    if (strb.commit)   memArr[wordIdx] <= {regWrData, stageLo, stageByte0};
  end

  always_comb begin
    regRdData = '0;
    if (regRdEn) begin
      unique case (selDec)
        SEL_CTRL: regRdData = matchEnable ? REG_W'(1) << FIELD_W
                                          : {curWord[BYTE_W-1:0], 1'b0, wordAddr};
        SEL_LO:   regRdData = matchEnable ? '0 : curWord[BYTE_W+REG_W-1:BYTE_W];
        SEL_HI:   regRdData = matchEnable ? '0 : curWord[WORD_W-1:BYTE_W+REG_W];
        default:  regRdData = '0;
      endcase
    end
  end

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> memArr[$past(wordIdx)] === $past(memArr[wordIdx])); // R7
endmodule

// File: rtl/pattern_mem_port.sv
module pattern_mem_port
  import pattern_mem_pkg::*;
#(
  parameter int REG_W   = 16,
  parameter int WORD_W  = 40,
  parameter int DEPTH   = 64,
  parameter int FIELD_W = 7
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     regWrEn,
  input  logic                     regRdEn,
  input  logic [1:0]               regSel,
  input  logic [REG_W-1:0]         regWrData,
  output logic [REG_W-1:0]         regRdData,
  output logic                     matchEnable,
  input  logic [$clog2(DEPTH)-1:0] mrdAddr,
  output logic [WORD_W-1:0]        mrdData
);
  strobe_t            strb;
  logic [FIELD_W-1:0] wordAddr;

  pattern_mem_ctrl #(.REG_W(REG_W), .FIELD_W(FIELD_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .matchEnable(matchEnable), .wordAddr(wordAddr),
    .strb(strb)
  );

  pattern_mem_dp #(.REG_W(REG_W), .WORD_W(WORD_W), .DEPTH(DEPTH), .FIELD_W(FIELD_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .matchEnable(matchEnable),
    .wordAddr(wordAddr), .regRdEn(regRdEn), .regSel(regSel),
    .regWrData(regWrData), .regRdData(regRdData), .mrdAddr(mrdAddr),
    .mrdData(mrdData)
  );

  AST_LOCK_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    (matchEnable && regRdEn && regSel == 2'd0) |-> regRdData[FIELD_W]); // R4
  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !regRdEn |-> regRdData == '0); // R1
endmodule

// File: tb/pattern_mem_port_tb.sv
`timescale 1ns/1ps
module pattern_mem_port_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [1:0]  regSel = 2'd0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        matchEnable;
  logic [5:0]  mrdAddr = '0;
  logic [39:0] mrdData;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [15:0] expQ[$];
  logic [15:0] maskQ[$];
  string       tagQ[$];

  always #4 clk = ~clk;

  pattern_mem_port dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regSel(regSel), .regWrData(regWrData), .regRdData(regRdData),
    .matchEnable(matchEnable), .mrdAddr(mrdAddr), .mrdData(mrdData)
  );

  // monitor: compares each read against the scoreboard queue
  always @(negedge clk) begin
    if (regRdEn && expQ.size() > 0) begin
      logic [15:0] e, m;
      string t;
      e = expQ.pop_front(); m = maskQ.pop_front(); t = tagQ.pop_front();
      checks++;
      if ((regRdData & m) !== (e & m)) begin
        fails++;
        $display("FAIL %s: read got %h expected %h (mask %h)", t, regRdData, e, m);
      end
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    @(posedge clk); #1;
    regWrEn = 1'b1; regSel = sel; regWrData = d;
    @(posedge clk); #1;
    regWrEn = 1'b0; regSel = 2'd0;
  endtask

  task automatic rd(input logic [1:0] sel, input logic [15:0] e,
                    input logic [15:0] m, input string t);
    @(posedge clk); #1;
    expQ.push_back(e); maskQ.push_back(m); tagQ.push_back(t);
    regRdEn = 1'b1; regSel = sel;
    @(posedge clk); #1;
    regRdEn = 1'b0; regSel = 2'd0;
  endtask

  task automatic chkMem(input logic [5:0] a, input logic [39:0] e, input string t);
    @(negedge clk);
    mrdAddr = a; #1;
    checks++;
    if (mrdData !== e) begin
      fails++;
      $display("FAIL %s: word %0d got %h expected %h", t, a, mrdData, e);
    end
  endtask

  task automatic chkBit(input logic act, input logic e, input string t);
    checks++;
    if (act !== e) begin
      fails++;
      $display("FAIL %s: got %b expected %b", t, act, e);
    end
  endtask

  task automatic doReset();
    @(posedge clk); #1; rstN = 1'b0;
    repeat (2) @(posedge clk);
    #1; rstN = 1'b1;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      summary();
    end
  end

  initial begin
    doReset();
    @(negedge clk);
    chkBit(matchEnable, 1'b0, "R1 reset mode");
    chkBit(regRdData == 16'h0, 1'b1, "R1 idle read zero");
    rd(2'd0, 16'h0000, 16'h00FF, "R1 reset address");

    // program word 0 and word 5
    wr(2'd0, 16'h3C00); wr(2'd1, 16'h5566); wr(2'd2, 16'h7788);
    wr(2'd0, 16'hA505); wr(2'd1, 16'h1234); wr(2'd2, 16'hBEEF);
    rd(2'd2, 16'hBEEF, 16'hFFFF, "R6 high read");
    rd(2'd0, 16'hA505, 16'hFFFF, "R6 control read");
    rd(2'd1, 16'h1234, 16'hFFFF, "R6 low read");
    chkMem(6'd5, 40'hBEEF_1234_A5, "R9 matcher port word 5");
    chkMem(6'd0, 40'h7788_5566_3C, "R9 matcher port word 0");

    // address bit 6 kept, word index from bits 5:0; commit only at high write
    wr(2'd0, 16'h0045);
    rd(2'd0, 16'hA545, 16'hFFFF, "R5 address bit 6 readback");
    wr(2'd1, 16'h0F0F);
    rd(2'd1, 16'h1234, 16'hFFFF, "R7 no change after low write");
    chkMem(6'd5, 40'hBEEF_1234_A5, "R7 word held before high write");
    wr(2'd2, 16'hF0F0);
    chkMem(6'd5, 40'hF0F0_0F0F_00, "R7 commit at high write");
    rd(2'd0, 16'h0045, 16'hFFFF, "R5 control after commit");

    // reads interleaved with the write sequence
    wr(2'd0, 16'h9907);
    rd(2'd0, 16'h0007, 16'h00FF, "R6 read inside sequence");
    wr(2'd1, 16'hAAAA);
    rd(2'd0, 16'h0007, 16'h00FF, "R6 read inside sequence 2");
    wr(2'd2, 16'hBBBB);
    chkMem(6'd7, 40'hBBBB_AAAA_99, "R6 sequence survives reads");

    // out of order sequences
    wr(2'd0, 16'h1107); wr(2'd2, 16'hCCCC);
    wr(2'd1, 16'hDDDD); wr(2'd2, 16'hEEEE);
    chkMem(6'd7, 40'hBBBB_AAAA_99, "R8 high without low");
    wr(2'd0, 16'h2207); wr(2'd1, 16'h1111); wr(2'd1, 16'h2222); wr(2'd2, 16'h3333);
    chkMem(6'd7, 40'hBBBB_AAAA_99, "R8 repeated low");
    wr(2'd0, 16'h3307); wr(2'd1, 16'h4444); wr(2'd3, 16'h0000); wr(2'd2, 16'h5555);
    chkMem(6'd7, 40'hBBBB_AAAA_99, "R8 unused select breaks sequence");
    wr(2'd0, 16'h4407); wr(2'd1, 16'h6666); wr(2'd2, 16'h7777);
    chkMem(6'd7, 40'h7777_6666_44, "R8 restart then full sequence");

    // matching mode lock
    wr(2'd0, 16'h5505); wr(2'd1, 16'h9999);
    wr(2'd0, 16'h0080);
    @(negedge clk);
    chkBit(matchEnable, 1'b1, "R2 mode set");
    rd(2'd0, 16'h0080, 16'hFFFF, "R4 control read locked");
    rd(2'd1, 16'h0000, 16'hFFFF, "R4 low read locked");
    rd(2'd2, 16'h0000, 16'hFFFF, "R4 high read locked");
    wr(2'd0, 16'hFFFF); wr(2'd1, 16'h1212); wr(2'd2, 16'h3434); wr(2'd2, 16'h8888);
    @(negedge clk);
    chkBit(matchEnable, 1'b1, "R3 mode held");
    chkMem(6'd5, 40'hF0F0_0F0F_00, "R3 word 5 untouched in lock");
    chkMem(6'd7, 40'h7777_6666_44, "R3 word 7 untouched in lock");
    chkMem(6'd0, 40'h7788_5566_3C, "R3 word 0 untouched in lock");
    wr(2'd0, 16'h0005);
    @(negedge clk);
    chkBit(matchEnable, 1'b0, "R2 mode cleared");
    wr(2'd2, 16'h6161);
    chkMem(6'd5, 40'hF0F0_0F0F_00, "R8 high right after unlock");
    rd(2'd1, 16'h0F0F, 16'hFFFF, "R3 low data after unlock");

    // reset keeps memory and drops a pending sequence
    wr(2'd0, 16'h0080);
    wr(2'd0, 16'h0000); wr(2'd1, 16'hABCD);
    wr(2'd0, 16'h0080);
    doReset();
    @(negedge clk);
    chkBit(matchEnable, 1'b0, "R1 mode after reset");
    rd(2'd0, 16'h3C00, 16'hFFFF, "R10 word 0 after reset");
    chkMem(6'd5, 40'hF0F0_0F0F_00, "R10 word 5 kept");
    chkMem(6'd7, 40'h7777_6666_44, "R10 word 7 kept");
    wr(2'd0, 16'h0000); wr(2'd1, 16'hABCD);
    doReset();
    wr(2'd2, 16'hDCBA);
    chkMem(6'd0, 40'h7788_5566_3C, "R10 interrupted sequence");
    @(negedge clk);
    chkBit(regRdData == 16'h0, 1'b1, "R1 idle read zero late");

    repeat (3) @(posedge clk);
    if (expQ.size() != 0) begin
      checks++; fails++;
      $display("FAIL R6: %0d reads not observed, expected 0", expQ.size());
    end
    done = 1;
    summary();
  end
endmodule